// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block sits inside a local interrupt unit and decides, in the same cycle, whether an inter-processor message on the command words is addressed to this unit. It holds three small registers: an identity word whose top byte is the physical ID, a logical-ID word whose top byte is the logical ID, and a destination-format word whose top nibble selects flat or cluster logical addressing.

A message is described by a low command word (which carries a two-bit shorthand and a destination-mode bit) and a high command word (which carries the 8-bit destination in its top byte). A separate flag tells the block whether the unit being tested is the message's sender. The block drives one accept bit. It also drives an error flag when a logical compare meets a format value it does not recognize.

Shorthand encodings bypass the address compare completely. Without a shorthand, the message is matched by physical ID, with 0xFF acting as broadcast, or by logical ID in flat or cluster form.

Top module: `ipi_dest_match`

## Requirements
- R1: After reset the identity word reads RESET_ID in bits 31:24 and zero elsewhere, the logical-ID word reads zero, and the format word reads 0xFFFFFFFF.
- R2: A write to the format word (wr_sel=2) stores the written bits 31:28 and forces bits 27:0 to one, visible on the cycle after the write edge.
- R3: A write to the identity word (wr_sel=0) stores all 32 bits; a write to the logical-ID word (wr_sel=1) keeps bits 31:24 and clears bits 23:0.
- R4: Shorthand 0 (cmd_lo bits 19:18) with destination mode 0 (cmd_lo bit 11) accepts when the destination (cmd_hi bits 31:24) is 0xFF or equals identity bits 31:24.
- R5: Shorthand 0 with destination mode 1 and format nibble 0xF (flat) accepts when the logical ID and the destination share at least one set bit.
- R6: Shorthand 0 with destination mode 1 and format nibble 0x0 (cluster) accepts only when the upper nibbles of the logical ID and the destination are equal and their lower nibbles share a set bit.
- R7: With shorthand 0, destination mode 1 and any other format nibble, accept is 0 and fmt_err is 1; in every other case fmt_err is 0.
- R8: Shorthand 1 (self) accepts exactly when src_is_self is 1, whatever the destination, mode and format.
- R9: Shorthand 2 (all including self) always accepts.
- R10: Shorthand 3 (all excluding self) accepts exactly when src_is_self is 0.
- R11: accept and fmt_err follow the command inputs in the same cycle, with no register on the path.
- R12: A write with wr_sel=3 changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the register writes |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 identity, 1 logical ID, 2 format, 3 none |
| wr_data | input | 32 | Write data |
| cmd_lo | input | 32 | Low command word: shorthand in bits 19:18, destination mode in bit 11 |
| cmd_hi | input | 32 | High command word: destination in bits 31:24 |
| src_is_self | input | 1 | The unit under test is the sender of the message |
| id_q | output | 32 | Identity word |
| ldr_q | output | 32 | Logical-ID word |
| fmt_q | output | 32 | Destination-format word |
| accept | output | 1 | Message is addressed to this unit |
| fmt_err | output | 1 | Logical compare met an unrecognized format |

## Verification
The accept and error results depend only on the inputs and the stored registers, so they are due in the same cycle the command is applied. The driver applies each command just after a falling edge and queues the expected pair. The monitor pops and compares that pair a quarter period later, before the next rising edge. A register write takes effect at the rising edge that follows the strobe, so register readback and any compare that uses the new value are sampled after the next falling edge.

// File: rtl/ipi_dest_match.sv
module ipi_dest_match #(
  parameter int WORD_W = 32,
  parameter int ID_W = 8,
  parameter logic [7:0] RESET_ID = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] cmd_lo,
  input  logic [WORD_W-1:0] cmd_hi,
  input  logic              src_is_self,
  output logic [WORD_W-1:0] id_q,
  output logic [WORD_W-1:0] ldr_q,
  output logic [WORD_W-1:0] fmt_q,
  output logic              accept,
  output logic              fmt_err
);
  localparam int ID_LSB = WORD_W - ID_W;
  localparam int HALF   = ID_W / 2;
  localparam int TAG_W  = 4;
  localparam int SH_LSB = 18;
  localparam int DM_BIT = 11;
  localparam logic [TAG_W-1:0] TAG_FLAT = '1;
  localparam logic [TAG_W-1:0] TAG_CLUS = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= {RESET_ID[ID_W-1:0], {ID_LSB{1'b0}}};
      ldr_q <= '0;
      fmt_q <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: id_q  <= wr_data;
        2'd1: ldr_q <= {wr_data[WORD_W-1 -: ID_W], {ID_LSB{1'b0}}};
        2'd2: fmt_q <= {wr_data[WORD_W-1 -: TAG_W], {(WORD_W-TAG_W){1'b1}}};
        default: ;
      endcase
    end
  end

  logic [1:0]      shand;
  logic            dmode;
  logic [ID_W-1:0] dest, my_id, my_log;
  logic [TAG_W-1:0] tag;
  logic is_flat, is_clus, phys_hit, flat_hit, clus_hit, log_hit;

  assign shand  = cmd_lo[SH_LSB +: 2];
  assign dmode  = cmd_lo[DM_BIT];
  assign dest   = cmd_hi[WORD_W-1 -: ID_W];
  assign my_id  = id_q[WORD_W-1 -: ID_W];
  assign my_log = ldr_q[WORD_W-1 -: ID_W];
  assign tag    = fmt_q[WORD_W-1 -: TAG_W];

  assign is_flat  = (tag == TAG_FLAT);
  assign is_clus  = (tag == TAG_CLUS);
  assign phys_hit = (dest == {ID_W{1'b1}}) || (dest == my_id);
  assign flat_hit = |(my_log & dest);
  assign clus_hit = (my_log[ID_W-1 -: HALF] == dest[ID_W-1 -: HALF]) &&
                    (|(my_log[HALF-1:0] & dest[HALF-1:0]));
  assign log_hit  = is_flat ? flat_hit : (is_clus ? clus_hit : 1'b0);

  always_comb begin
    case (shand)
      2'd0:    accept = dmode ? log_hit : phys_hit;
      2'd1:    accept = src_is_self;
      2'd2:    accept = 1'b1;
      default: accept = !src_is_self;
    endcase
  end

  assign fmt_err = (shand == 2'd0) && dmode && !is_flat && !is_clus;

  logic unused_bits;
  assign unused_bits = ^{cmd_lo[WORD_W-1:SH_LSB+2], cmd_lo[SH_LSB-1:DM_BIT+1],
                         cmd_lo[DM_BIT-1:0], cmd_hi[ID_LSB-1:0], id_q[ID_LSB-1:0],
                         ldr_q[ID_LSB-1:0], fmt_q[WORD_W-TAG_W-1:0]};

  assert_fmt_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2) |=>
      (fmt_q == {$past(wr_data[WORD_W-1 -: TAG_W]), {(WORD_W-TAG_W){1'b1}}}));
  assert_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shand == 2'd0 && !dmode && dest == {ID_W{1'b1}}) |-> accept);
  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !accept);
  assert_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (shand == 2'd1) |-> (accept == src_is_self));
  assert_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shand == 2'd2) |-> accept);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shand == 2'd3) |-> (accept == !src_is_self));
  assert_noreg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> ($stable(id_q) && $stable(ldr_q) && $stable(fmt_q)));
endmodule

// File: tb/sim_ipi_dest_match.sv
module sim_ipi_dest_match;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, src_is_self = 0;
  logic [1:0] wr_sel = 0;
  logic [31:0] wr_data = 0, cmd_lo = 0, cmd_hi = 0;
  logic [31:0] id_q, ldr_q, fmt_q;
  logic accept, fmt_err;

  ipi_dest_match u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .src_is_self(src_is_self),
    .id_q(id_q), .ldr_q(ldr_q), .fmt_q(fmt_q), .accept(accept), .fmt_err(fmt_err));

  always #(PERIOD/2) clk = ~clk;

  typedef struct { logic acc; logic err; string req; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_id = 8'h03, m_log = 8'h00;
  logic [3:0] m_tag = 4'hF;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [1:0] sh, input logic dm,
                                       input logic [7:0] d, input logic self);
    logic a, e;
    a = 0; e = 0;
    if (sh == 2'd1) a = self;
    else if (sh == 2'd2) a = 1;
    else if (sh == 2'd3) a = !self;
    else if (!dm) a = (d == 8'hFF) || (d == m_id);
    else if (m_tag == 4'hF) a = (m_log & d) != 0;
    else if (m_tag == 4'h0) a = (m_log[7:4] == d[7:4]) && ((m_log[3:0] & d[3:0]) != 0);
    else e = 1;
    return {a, e};
  endfunction

  task automatic send(input logic [1:0] sh, input logic dm, input logic [7:0] d,
                      input logic self, input string req);
    logic [1:0] x;
    item_t it;
    @(negedge clk);
    cmd_lo = 32'h5A5A_5A5A;
    cmd_lo[19:18] = sh;
    cmd_lo[11] = dm;
    cmd_hi = {d, 24'hC3_3C_96};
    src_is_self = self;
    x = model(sh, dm, d, self);
    it.acc = x[1]; it.err = x[0]; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 0;
    #(PERIOD/4);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(accept === it.acc && fmt_err === it.err, it.req,
            {30'd0, accept, fmt_err}, {30'd0, it.acc, it.err});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #(PERIOD/4);
    chk(id_q == 32'h0300_0000, "R1 id", id_q, 32'h0300_0000);
    chk(ldr_q == 32'h0, "R1 ldr", ldr_q, 32'h0);
    chk(fmt_q == 32'hFFFF_FFFF, "R1 fmt", fmt_q, 32'hFFFF_FFFF);
    rst_n = 1;
    send(2'd0, 0, 8'h03, 0, "R4 reset id");
    wr(2'd0, 32'h2A00_1234); m_id = 8'h2A;
    chk(id_q == 32'h2A00_1234, "R3 id full", id_q, 32'h2A00_1234);
    send(2'd0, 0, 8'h2A, 0, "R4 id hit");
    send(2'd0, 0, 8'hFF, 0, "R4 broadcast");
    send(2'd0, 0, 8'h2B, 1, "R4 miss");
    send(2'd0, 0, 8'h00, 0, "R4 zero");
    wr(2'd1, 32'hC5FF_FFFF); m_log = 8'hC5;
    chk(ldr_q == 32'hC500_0000, "R3 ldr mask", ldr_q, 32'hC500_0000);
    send(2'd0, 1, 8'h04, 0, "R5 flat hit");
    send(2'd0, 1, 8'h3A, 0, "R5 flat miss");
    send(2'd0, 1, 8'h00, 0, "R5 flat zero");
    send(2'd0, 1, 8'h80, 0, "R5 flat top");
    wr(2'd2, 32'h0000_0000); m_tag = 4'h0;
    chk(fmt_q == 32'h0FFF_FFFF, "R2 cluster write", fmt_q, 32'h0FFF_FFFF);
    send(2'd0, 1, 8'hC1, 0, "R6 cluster hit");
    send(2'd0, 1, 8'hC4, 0, "R6 cluster hit2");
    send(2'd0, 1, 8'hC2, 0, "R6 cluster low miss");
    send(2'd0, 1, 8'hD5, 0, "R6 cluster high miss");
    send(2'd0, 1, 8'hFF, 0, "R6 cluster ff");
    wr(2'd2, 32'h5123_4567); m_tag = 4'h5;
    chk(fmt_q == 32'h5FFF_FFFF, "R2 odd write", fmt_q, 32'h5FFF_FFFF);
    send(2'd0, 1, 8'hC5, 0, "R7 bad format");
    send(2'd0, 0, 8'h2A, 0, "R7 physical no err");
    send(2'd1, 1, 8'hC5, 1, "R7 shorthand no err");
    send(2'd1, 0, 8'h11, 1, "R8 self sender");
    send(2'd1, 0, 8'h2A, 0, "R8 self other");
    send(2'd2, 1, 8'h00, 0, "R9 all incl");
    send(2'd2, 0, 8'h77, 1, "R9 all incl self");
    send(2'd3, 0, 8'h2A, 1, "R10 excl sender");
    send(2'd3, 1, 8'h00, 0, "R10 excl other");
    wr(2'd3, 32'h0000_0000);
    chk(id_q == 32'h2A00_1234, "R12 id", id_q, 32'h2A00_1234);
    chk(ldr_q == 32'hC500_0000, "R12 ldr", ldr_q, 32'hC500_0000);
    chk(fmt_q == 32'h5FFF_FFFF, "R12 fmt", fmt_q, 32'h5FFF_FFFF);
    wr(2'd2, 32'hF000_0000); m_tag = 4'hF;
    chk(fmt_q == 32'hFFFF_FFFF, "R2 flat write", fmt_q, 32'hFFFF_FFFF);
    send(2'd0, 1, 8'h40, 0, "R11 flat same cycle");
    send(2'd0, 1, 8'h02, 0, "R11 next cycle miss");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R11 drained", sb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule